// File: doc/BRIEF.md
# Control-Register High-Word Access Unit

This block carries out the two privileged instructions that move a 32-bit word into, or out of, the upper half of a 64-bit system-control register. It keeps four such registers: two translation-entry low registers (even and odd page), a load-linked address register and a cache tag-low register. Each cycle it may take one instruction word, strobed by `valid`, together with the low 32 bits of the source general register. One clock edge later it reports a write-back for the general register, or a reserved-instruction trap.

Three side inputs govern each access. A configuration enable bit turns the whole feature on: when it is clear, a recognised instruction only traps. An extended-physical-addressing flag also gates access, but without a trap: reads return zero and writes are dropped. A physical-address mask trims every stored word to the address bits the chip implements, and the amount it is shifted down depends on the register being written.

With `WIDE_MODE` set (64-bit general registers), the upper word of each translation-entry register sits at bits 61:30. This keeps clear of the two protection flags held in bits 63:62. Read results are sign-extended to 64 bits.

Top module: `hiword_access_unit`

## Requirements
- R1: An instruction is recognised only when `instr & 0xFFE007F8` equals `0x40400000` (read-high) or `0x40C00000` (write-high). Any other word strobed with `valid` produces no write-back, no trap and no change to register state.
- R2: When `hiEnable` is low, a recognised instruction sets `riExc` for one cycle. It produces no write-back and changes no register.
- R3: When `extPaEn` is low, a read-high with a nonzero destination writes back zero, and a write-high changes no register.
- R4: The register number is `instr[15:11]` and the select is `instr[2:0]`. Register 2/select 0 is the even entry register, 3/0 is the odd entry register, 17/0 is the load-linked address, and 28 with select 0, 2, 4 or 6 is the tag register. Every other pair reads as zero and ignores writes.
- R5: In wide mode, a write-high to an entry register places the masked word into bits 61:30 and leaves bits 63:62 and 29:0 unchanged.
- R6: In wide mode, a read-high of an entry register returns bits 61:30 only (never the protection flags), sign-extended to 64 bits.
- R7: For the load-linked and tag registers, the upper word is bits 63:32. A write keeps bits 31:0, and a read returns bits 63:32 sign-extended.
- R8: A read-high whose destination field `instr[20:16]` is 0 gives no write-back.
- R9: The word is ANDed with a mask before it is stored. The mask is the low 32 bits of `paMask >> 36` for entry registers, and the low 32 bits of `paMask >> 32` for the load-linked and tag registers.
- R10: Results appear on the cycle after the `valid` edge: `wbEn`, `wbIdx` (equal to the destination field) and `rdData`, or `riExc`. `wbEn` and `riExc` are never high together. A write is visible to a read issued on the very next cycle.
- R11: Reset clears all four registers and the outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| srcWord | input | 32 | Low word of the source general register |
| hiEnable | input | 1 | Configuration enable for high-word access |
| extPaEn | input | 1 | Extended physical addressing active |
| paMask | input | 64 | Implemented physical-address mask |
| rdData | output | GPR_W (64) | Read result for write-back |
| wbEn | output | 1 | General-register write-back enable |
| wbIdx | output | 5 | General-register index for write-back |
| riExc | output | 1 | Reserved-instruction exception |

## Verification
The properties assume that `hiEnable`, `extPaEn` and `paMask` change only in cycles where `valid` is low. They also assume that `valid` is low during reset. The stimulus changes these configuration inputs only after an idle cycle, and it holds `valid` low until reset is released. Nothing can write the entry-register protection flags or low bits. The checker therefore demands that those bits stay constant, and the bench observes the placement through reads that follow writes.

// File: rtl/hiword_pkg.sv
package hiword_pkg;

  localparam logic [31:0] OP_FIELD_MASK  = 32'hFFE0_07F8;
  localparam logic [31:0] READ_HI_MATCH  = 32'h4040_0000;
  localparam logic [31:0] WRITE_HI_MATCH = 32'h40C0_0000;
  localparam int          NUM_TARGETS    = 4;
  localparam int          SLOT_W         = $clog2(NUM_TARGETS);

  typedef enum logic [2:0] {
    TGT_NONE       = 3'd0,
    TGT_ENTRY_EVEN = 3'd1,
    TGT_ENTRY_ODD  = 3'd2,
    TGT_LINK_ADDR  = 3'd3,
    TGT_TAG        = 3'd4
  } hiTarget_e;

  typedef struct packed {
    logic              writeStb;
    logic              readStb;
    logic              readZero;
    logic [SLOT_W-1:0] slot;
  } hiStrobe_t;

  function automatic hiTarget_e decodeTarget(input logic [4:0] regNum, input logic [2:0] sel);
    hiTarget_e t;
    t = TGT_NONE;
    if (regNum == 5'd2 && sel == 3'd0)       t = TGT_ENTRY_EVEN;
    else if (regNum == 5'd3 && sel == 3'd0)  t = TGT_ENTRY_ODD;
    else if (regNum == 5'd17 && sel == 3'd0) t = TGT_LINK_ADDR;
    else if (regNum == 5'd28 && !sel[0])     t = TGT_TAG;
    return t;
  endfunction

  function automatic logic [SLOT_W-1:0] targetSlot(input hiTarget_e t);
    logic [SLOT_W-1:0] s;
    case (t)
      TGT_ENTRY_ODD: s = SLOT_W'(1);
      TGT_LINK_ADDR: s = SLOT_W'(2);
      TGT_TAG:       s = SLOT_W'(3);
      default:       s = SLOT_W'(0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hiword_control.sv
module hiword_control
  import hiword_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic [31:0] instr,
  input  logic        hiEnable,
  input  logic        extPaEn,
  output hiStrobe_t   strobe,
  output logic        wbEn,
  output logic [4:0]  wbIdx,
  output logic        riExc
);

  logic      wordIsRead;
  logic      wordIsWrite;
  logic      trapNow;
  hiTarget_e target;
  logic [4:0] destIdx;

  assign destIdx = instr[20:16];

  always_comb begin
    wordIsRead  = (instr & OP_FIELD_MASK) == READ_HI_MATCH;
    wordIsWrite = (instr & OP_FIELD_MASK) == WRITE_HI_MATCH;
    target      = decodeTarget(instr[15:11], instr[2:0]);
    trapNow     = valid && (wordIsRead || wordIsWrite) && !hiEnable;
    strobe.readStb  = valid && wordIsRead && hiEnable && (destIdx != 5'd0);
    strobe.writeStb = valid && wordIsWrite && hiEnable && extPaEn && (target != TGT_NONE);
    strobe.readZero = !extPaEn || (target == TGT_NONE);
    strobe.slot     = targetSlot(target);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riExc <= 1'b0;
      wbEn  <= 1'b0;
      wbIdx <= 5'd0;
    end else begin
      riExc <= trapNow;
      wbEn  <= strobe.readStb;
      if (strobe.readStb) wbIdx <= destIdx;
    end
  end

endmodule

// File: rtl/hiword_datapath.sv
module hiword_datapath
  import hiword_pkg::*;
#(
  parameter bit WIDE_MODE        = 1'b1,
  parameter int GPR_W            = 64,
  parameter int ENTRY_MASK_SHIFT = 36,
  parameter int LINK_MASK_SHIFT  = 32,
  parameter int TAG_MASK_SHIFT   = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  hiStrobe_t                   strobe,
  input  logic [31:0]                 srcWord,
  input  logic [63:0]                 paMask,
  output logic [GPR_W-1:0]            rdData,
  output logic [NUM_TARGETS-1:0][63:0] regsView
);

  localparam int ENTRY_SLOTS = 2;

  for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_slot
    localparam bit IS_ENTRY = (g < ENTRY_SLOTS);
    localparam int SHIFT    = IS_ENTRY ? ENTRY_MASK_SHIFT :
                              ((g == 2) ? LINK_MASK_SHIFT : TAG_MASK_SHIFT);
    logic [63:0] slotQ;
    logic [31:0] maskedWord;

    assign maskedWord = srcWord & 32'(paMask >> SHIFT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotQ <= 64'd0;
      end else if (strobe.writeStb && (strobe.slot == SLOT_W'(g))) begin
        if (WIDE_MODE && IS_ENTRY) slotQ[61:30] <= maskedWord;
        else                       slotQ[63:32] <= maskedWord;
      end
    end

    assign regsView[g] = slotQ;
  end

  logic [63:0] picked;
  logic [31:0] hiWord;
  logic [31:0] readWord;

  always_comb begin
    picked = regsView[strobe.slot];
    if (WIDE_MODE && (strobe.slot < SLOT_W'(ENTRY_SLOTS))) hiWord = picked[61:30];
    else                                                  hiWord = picked[63:32];
    readWord = strobe.readZero ? 32'd0 : hiWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.readStb) rdData <= GPR_W'(signed'(readWord));
  end

endmodule

// File: rtl/hiword_access_unit.sv
module hiword_access_unit
  import hiword_pkg::*;
#(
  parameter bit WIDE_MODE        = 1'b1,
  parameter int ENTRY_MASK_SHIFT = 36,
  parameter int LINK_MASK_SHIFT  = 32,
  parameter int TAG_MASK_SHIFT   = 32,
  localparam int GPR_W           = WIDE_MODE ? 64 : 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic [31:0]      instr,
  input  logic [31:0]      srcWord,
  input  logic             hiEnable,
  input  logic             extPaEn,
  input  logic [63:0]      paMask,
  output logic [GPR_W-1:0] rdData,
  output logic             wbEn,
  output logic [4:0]       wbIdx,
  output logic             riExc
);

  hiStrobe_t                    strobe;
  logic [NUM_TARGETS-1:0][63:0] regsView;

  hiword_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .valid    (valid),
    .instr    (instr),
    .hiEnable (hiEnable),
    .extPaEn  (extPaEn),
    .strobe   (strobe),
    .wbEn     (wbEn),
    .wbIdx    (wbIdx),
    .riExc    (riExc)
  );

  hiword_datapath #(
    .WIDE_MODE        (WIDE_MODE),
    .GPR_W            (GPR_W),
    .ENTRY_MASK_SHIFT (ENTRY_MASK_SHIFT),
    .LINK_MASK_SHIFT  (LINK_MASK_SHIFT),
    .TAG_MASK_SHIFT   (TAG_MASK_SHIFT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcWord  (srcWord),
    .paMask   (paMask),
    .rdData   (rdData),
    .regsView (regsView)
  );

endmodule

// File: rtl/hiword_access_checker.sv
module hiword_access_checker
  import hiword_pkg::*;
#(
  parameter bit WIDE_MODE = 1'b1
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        valid,
  input logic                        hiEnable,
  input logic                        extPaEn,
  input logic                        wbEn,
  input logic [4:0]                  wbIdx,
  input logic                        riExc,
  input logic [NUM_TARGETS-1:0][63:0] regsView
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_EXC_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(riExc && wbEn)); // R10

  AST_RESULT_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (wbEn || riExc)) |-> $past(valid)); // R10

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && riExc) |-> $past(!hiEnable)); // R2

  AST_TRAP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && riExc) |-> (regsView == $past(regsView))); // R2

  AST_NO_EXTPA_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(valid && !extPaEn)) |-> (regsView == $past(regsView))); // R3

  AST_WB_NONZERO_DEST: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbIdx != 5'd0)); // R8

  AST_PROT_BITS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ($stable(regsView[0][63:62]) && $stable(regsView[1][63:62]))); // R5

  if (WIDE_MODE) begin : g_wide
    AST_ENTRY_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      armed |-> ($stable(regsView[0][29:0]) && $stable(regsView[1][29:0]))); // R5
  end

  AST_OTHER_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ($stable(regsView[2][31:0]) && $stable(regsView[3][31:0]))); // R7

endmodule

bind hiword_access_unit hiword_access_checker #(.WIDE_MODE(WIDE_MODE)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .valid    (valid),
  .hiEnable (hiEnable),
  .extPaEn  (extPaEn),
  .wbEn     (wbEn),
  .wbIdx    (wbIdx),
  .riExc    (riExc),
  .regsView (regsView)
);

// File: tb/hiword_access_unit_tb_top.sv
`timescale 1ns/1ps
module hiword_access_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        valid;
  logic [31:0] instr;
  logic [31:0] srcWord;
  logic        hiEnable;
  logic        extPaEn;
  logic [63:0] paMask;
  logic [63:0] rdData;
  logic        wbEn;
  logic [4:0]  wbIdx;
  logic        riExc;

  always #4 clk = ~clk;

  hiword_access_unit dut_i (
    .clk(clk), .rstN(rstN), .valid(valid), .instr(instr), .srcWord(srcWord),
    .hiEnable(hiEnable), .extPaEn(extPaEn), .paMask(paMask),
    .rdData(rdData), .wbEn(wbEn), .wbIdx(wbIdx), .riExc(riExc)
  );

  typedef struct {
    logic        wb;
    logic [4:0]  idx;
    logic [63:0] data;
    logic        exc;
    string       req;
  } expItem_t;

  expItem_t    expQ[$];
  logic [63:0] model [4];
  int checks = 0;
  int fails  = 0;

  function automatic logic [31:0] mk(input bit wr, input int rt, input int rd, input int sel);
    return (wr ? 32'h40C0_0000 : 32'h4040_0000) | (32'(rt) << 16) | (32'(rd) << 11) | 32'(sel);
  endfunction

  function automatic int slotOf(input int rd, input int sel);
    if (rd == 2 && sel == 0) return 0;
    if (rd == 3 && sel == 0) return 1;
    if (rd == 17 && sel == 0) return 2;
    if (rd == 28 && (sel % 2) == 0) return 3;
    return -1;
  endfunction

  // Drive one instruction and push what the requirements predict for it.
  task automatic issue(input logic [31:0] word, input logic [31:0] src, input string req);
    expItem_t e;
    bit isRd, isWr;
    int rt, s;
    logic [31:0] hi, m;
    isRd = (word & 32'hFFE0_07F8) == 32'h4040_0000;
    isWr = (word & 32'hFFE0_07F8) == 32'h40C0_0000;
    rt = int'(word[20:16]);
    s  = slotOf(int'(word[15:11]), int'(word[2:0]));
    e.wb = 0; e.exc = 0; e.idx = word[20:16]; e.data = 64'd0; e.req = req;
    if (isRd || isWr) begin
      if (!hiEnable) e.exc = 1;
      else if (isRd) begin
        if (rt != 0) begin
          e.wb = 1;
          if (!extPaEn || s < 0) hi = 32'd0;
          else if (s < 2)        hi = model[s][61:30];
          else                   hi = model[s][63:32];
          e.data = {{32{hi[31]}}, hi};
        end
      end else if (extPaEn && s >= 0) begin
        m = src & 32'(paMask >> ((s < 2) ? 36 : 32));
        if (s < 2) model[s][61:30] = m;
        else       model[s][63:32] = m;
      end
    end
    @(negedge clk);
    instr = word; srcWord = src; valid = 1'b1;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; instr = 32'd0; srcWord = 32'd0;
  endtask

  // Monitor: compare outputs after each active edge.
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #2;
      if (rstN === 1'b1) begin
        checks++;
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          if (wbEn !== e.wb || riExc !== e.exc || (e.wb && (wbIdx !== e.idx || rdData !== e.data))) begin
            fails++;
            $display("FAIL %s: wb=%0b exc=%0b idx=%0d data=%h expected wb=%0b exc=%0b idx=%0d data=%h",
                     e.req, wbEn, riExc, wbIdx, rdData, e.wb, e.exc, e.idx, e.data);
          end
        end else if (wbEn !== 1'b0 || riExc !== 1'b0) begin
          fails++;
          $display("FAIL R10 idle: wb=%0b exc=%0b expected wb=0 exc=0", wbEn, riExc);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 64'd0;
    rstN = 1'b0; valid = 1'b0; instr = 32'd0; srcWord = 32'd0;
    hiEnable = 1'b1; extPaEn = 1'b1; paMask = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    checks++;
    if (wbEn !== 1'b0 || riExc !== 1'b0 || rdData !== 64'd0) begin
      fails++;
      $display("FAIL R11 reset outputs: wb=%0b exc=%0b data=%h expected 0 0 0", wbEn, riExc, rdData);
    end
    rstN = 1'b1;

    // R11: all registers read zero after reset
    issue(mk(0, 1, 2, 0), 0, "R11");
    issue(mk(0, 2, 3, 0), 0, "R11");
    issue(mk(0, 3, 17, 0), 0, "R11");
    issue(mk(0, 4, 28, 0), 0, "R11");

    // R5/R6: entry registers, negative and positive words
    issue(mk(1, 9, 2, 0), 32'hDEAD_BEEF, "R5");
    issue(mk(0, 5, 2, 0), 0, "R6");
    issue(mk(1, 9, 3, 0), 32'h1234_5678, "R5");
    issue(mk(0, 6, 3, 0), 0, "R6");

    // R7: load-linked and tag use the top word
    issue(mk(1, 1, 17, 0), 32'h8000_0001, "R7");
    issue(mk(0, 7, 17, 0), 0, "R7");
    issue(mk(1, 1, 28, 4), 32'hCAFE_F00D, "R7");
    issue(mk(0, 8, 28, 0), 0, "R4");
    issue(mk(0, 8, 28, 2), 0, "R4");
    issue(mk(0, 8, 28, 6), 0, "R4");

    // R4: unsupported pairs
    issue(mk(1, 3, 2, 1), 32'h5555_5555, "R4");
    issue(mk(0, 3, 2, 1), 0, "R4");
    issue(mk(0, 3, 28, 1), 0, "R4");
    issue(mk(0, 3, 5, 0), 0, "R4");
    issue(mk(1, 3, 17, 1), 32'h7777_7777, "R4");
    issue(mk(0, 10, 2, 0), 0, "R4");
    issue(mk(0, 10, 17, 0), 0, "R4");

    // R8: destination zero
    issue(mk(0, 0, 2, 0), 0, "R8");

    // R1: near-miss words
    issue(32'h4040_0008 | (32'd5 << 16) | (32'd2 << 11), 0, "R1");
    issue(32'h4080_0000 | (32'd3 << 11), 32'h1111_1111, "R1");
    issue(32'h40C0_0010 | (32'd2 << 11), 32'h2222_2222, "R1");
    issue(32'h4000_0000 | (32'd5 << 16) | (32'd2 << 11), 0, "R1");
    issue(mk(0, 11, 2, 0), 0, "R1");
    issue(mk(0, 11, 3, 0), 0, "R1");

    // R2: disabled feature traps
    idle(); hiEnable = 1'b0;
    issue(mk(1, 2, 3, 0), 32'hAAAA_AAAA, "R2");
    issue(mk(0, 2, 3, 0), 0, "R2");
    idle(); hiEnable = 1'b1;
    issue(mk(0, 12, 3, 0), 0, "R2");

    // R3: extended addressing off
    idle(); extPaEn = 1'b0;
    issue(mk(1, 2, 2, 0), 32'h0BAD_F00D, "R3");
    issue(mk(0, 13, 2, 0), 0, "R3");
    idle(); extPaEn = 1'b1;
    issue(mk(0, 13, 2, 0), 0, "R3");

    // R9: per-register masks
    idle(); paMask = 64'h0000_0FFF_FFFF_FFFF;
    issue(mk(1, 2, 2, 0), 32'hFFFF_FFFF, "R9");
    issue(mk(0, 14, 2, 0), 0, "R9");
    issue(mk(1, 2, 17, 0), 32'hFFFF_FFFF, "R9");
    issue(mk(0, 14, 17, 0), 0, "R9");
    issue(mk(1, 2, 28, 2), 32'hFFFF_FFFF, "R9");
    issue(mk(0, 14, 28, 0), 0, "R9");

    // R10: back-to-back write then read, consecutive reads
    idle(); paMask = 64'hFFFF_FFFF_FFFF_FFFF;
    issue(mk(1, 2, 3, 0), 32'h7FFF_FFFF, "R10");
    issue(mk(0, 15, 3, 0), 0, "R10");
    issue(mk(0, 31, 17, 0), 0, "R10");
    issue(mk(0, 16, 28, 6), 0, "R10");
    idle();
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule